// File: doc/BRIEF.md
# Fast Link Drop Error Monitor

This block watches a running link for error bursts and loss of signal and decides when the link must be forced down at once, without waiting for slower link-integrity timers. Three error sources, each a single-cycle event strobe, are counted over a shared window of `WIN_CYC` clock cycles. These are receive-side errors, line-code violations and low-SNR threshold crossings. Each source has its own threshold. A fourth input, an energy-loss level, acts without a window. It triggers once it has been held for a full reaction interval of `LOSS_CYC` cycles.

A 4-bit enable mask selects which of the four conditions may cause a drop. The output is a one-cycle pulse that is the OR of every enabled condition reaching its limit. Each pulse restarts the window, every counter and the energy-loss timer. The defaults assume a 25 MHz clock, so one 10 µs window is 250 cycles. The block sits between the line detectors and the link state machine, which consumes the pulse.

Top module: `link_drop_mon`

## Requirements
- R1: With `en_i[3]` set, the `RX_TH`-th (default 32) `rx_err_i` event inside one window produces a drop.
- R2: With `en_i[2]` set, the `CODE_TH`-th (default 20) `code_err_i` event inside one window produces a drop.
- R3: With `en_i[1]` set, the `SNR_TH`-th (default 20) `snr_err_i` event inside one window produces a drop.
- R4: With `en_i[0]` set, `loss_i` held high for `LOSS_CYC` (default 250) consecutive cycles produces a drop on the last of them. Any low cycle restarts the interval.
- R5: `drop_o` is high for exactly one cycle, the cycle after the clock edge that samples the triggering input. Sources that reach their limit together give a single pulse.
- R6: A window is `WIN_CYC` cycles long and starts at reset release or after a drop. Event counts clear at the end of each window. An event in the last cycle of a window still counts towards a threshold reached in that cycle, and counts never exceed their threshold.
- R7: While a source's enable bit is 0, its count or timer is held at zero and that source cannot cause a drop.
- R8: A drop restarts the window and clears all three event counts and the energy-loss timer.
- R9: During reset and in the first cycle after it, `drop_o` is 0 and all counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 4 | Enables: [3] receive error, [2] line-code, [1] low SNR, [0] energy loss |
| rx_err_i | input | 1 | Receive-error event strobe |
| code_err_i | input | 1 | Line-code violation event strobe |
| snr_err_i | input | 1 | Low-SNR crossing event strobe |
| loss_i | input | 1 | Energy-loss level |
| drop_o | output | 1 | One-cycle link-drop pulse |

## Verification
Every result of this block appears one cycle after the edge that samples the triggering event. The threshold compare and the energy-loss compare are combinational on the current count, and only the drop register lies between them and `drop_o`. The bench drives each cycle's inputs before a rising edge and reads `drop_o` one nanosecond after that same edge. It then matches the pulse to the exact event index it expects, with the first event counted as 1. Window phase is anchored at reset release or at a drop. The window tests therefore place events at cycle offsets from those points, so that the window end, or a window that failed to restart, changes the outcome.

// File: rtl/link_drop_pkg.sv
package link_drop_pkg;

  localparam int NUM_CNT = 3;

  // index into the windowed counter array; en_i bit is index + 1
  typedef enum int unsigned {
    SRC_SNR  = 0,
    SRC_CODE = 1,
    SRC_RX   = 2
  } cnt_src_e;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ldm_window.sv
module ldm_window #(
  parameter int WIN_CYC = 250,
  localparam int WIN_W  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic             win_end_o,
  output logic [WIN_W-1:0] win_cnt_o
);

  logic [WIN_W-1:0] cnt_q;

  assign win_end_o = (cnt_q == WIN_W'(WIN_CYC - 1));
  assign win_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (restart_i || win_end_o) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ldm_evt_cnt.sv
module ldm_evt_cnt #(
  parameter int TH    = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  // threshold seen the moment the last needed event arrives
  assign hit_o = en_i && evt_i && (cnt_q == CNT_W'(TH - 1));
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (!en_i || clr_i)                 cnt_q <= '0;
    else if (evt_i && (cnt_q < CNT_W'(TH)))  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ldm_loss_filt.sv
module ldm_loss_filt #(
  parameter int LOSS_CYC = 250,
  localparam int LOSS_W  = (LOSS_CYC > 1) ? $clog2(LOSS_CYC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              loss_i,
  input  logic              restart_i,
  output logic              hit_o,
  output logic [LOSS_W-1:0] cnt_o
);

  logic [LOSS_W-1:0] cnt_q;
  logic              full;

  assign full  = (cnt_q == LOSS_W'(LOSS_CYC - 1));
  assign hit_o = en_i && loss_i && full;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!en_i || !loss_i || restart_i) cnt_q <= '0;
    else if (!full)                       cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/link_drop_mon.sv
module link_drop_mon
  import link_drop_pkg::*;
#(
  parameter int WIN_CYC  = 250,
  parameter int RX_TH    = 32,
  parameter int CODE_TH  = 20,
  parameter int SNR_TH   = 20,
  parameter int LOSS_CYC = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] en_i,
  input  logic       rx_err_i,
  input  logic       code_err_i,
  input  logic       snr_err_i,
  input  logic       loss_i,
  output logic       drop_o
);

  localparam int WIN_W  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int LOSS_W = (LOSS_CYC > 1) ? $clog2(LOSS_CYC) : 1;
  localparam int MAX_TH = max_of3(RX_TH, CODE_TH, SNR_TH);
  localparam int CNT_W  = $clog2(MAX_TH + 1);
  localparam int TH_TAB [NUM_CNT] = '{SNR_TH, CODE_TH, RX_TH};

  logic                            win_end;
  logic [WIN_W-1:0]                win_cnt;
  logic [NUM_CNT-1:0]              evt;
  logic [NUM_CNT-1:0]              cnt_hit;
  logic [NUM_CNT-1:0][CNT_W-1:0]   evt_cnt;
  logic                            loss_hit;
  logic [LOSS_W-1:0]               loss_cnt;
  logic                            trig;
  logic                            drop_q;

  assign evt  = {rx_err_i, code_err_i, snr_err_i};
  assign trig = (|cnt_hit) || loss_hit;

  ldm_window #(
    .WIN_CYC(WIN_CYC)
  ) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (trig),
    .win_end_o (win_end),
    .win_cnt_o (win_cnt)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    ldm_evt_cnt #(
      .TH    (TH_TAB[g]),
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i[g+1]),
      .evt_i  (evt[g]),
      .clr_i  (win_end || trig),
      .hit_o  (cnt_hit[g]),
      .cnt_o  (evt_cnt[g])
    );
  end

  ldm_loss_filt #(
    .LOSS_CYC(LOSS_CYC)
  ) u_loss (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i[0]),
    .loss_i    (loss_i),
    .restart_i (trig),
    .hit_o     (loss_hit),
    .cnt_o     (loss_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_q <= 1'b0;
    else         drop_q <= trig;
  end

  assign drop_o = drop_q;

endmodule

// File: rtl/link_drop_mon_chk.sv
module link_drop_mon_chk
  import link_drop_pkg::*;
#(
  parameter int RX_TH   = 32,
  parameter int CODE_TH = 20,
  parameter int SNR_TH  = 20,
  parameter int WIN_W   = 8,
  parameter int CNT_W   = 6,
  parameter int LOSS_W  = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [3:0]                    en_i,
  input logic                          loss_i,
  input logic                          drop_o,
  input logic [WIN_W-1:0]              win_cnt,
  input logic [NUM_CNT-1:0][CNT_W-1:0] evt_cnt,
  input logic [LOSS_W-1:0]             loss_cnt
);

  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> !drop_o);

  a_r8_all_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (win_cnt == '0 && evt_cnt == '0 && loss_cnt == '0));

  a_r7_mask_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == 4'b0000) |=> !drop_o);

  a_r7_rx_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[3] |=> (evt_cnt[SRC_RX] == '0));

  a_r7_loss_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[0] |=> (loss_cnt == '0));

  a_r4_loss_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && $past(en_i) == 4'b0001) |-> $past(loss_i));

  a_r6_rx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_cnt[SRC_RX] < CNT_W'(RX_TH));

  a_r6_code_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_cnt[SRC_CODE] < CNT_W'(CODE_TH));

  a_r6_snr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_cnt[SRC_SNR] < CNT_W'(SNR_TH));

endmodule

bind link_drop_mon link_drop_mon_chk #(
  .RX_TH   (RX_TH),
  .CODE_TH (CODE_TH),
  .SNR_TH  (SNR_TH),
  .WIN_W   (WIN_W),
  .CNT_W   (CNT_W),
  .LOSS_W  (LOSS_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .loss_i   (loss_i),
  .drop_o   (drop_o),
  .win_cnt  (win_cnt),
  .evt_cnt  (evt_cnt),
  .loss_cnt (loss_cnt)
);

// File: tb/link_drop_mon_tb.sv
module link_drop_mon_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] en = 4'b0000;
  logic       rx = 1'b0, code = 1'b0, snr = 1'b0, loss = 1'b0;
  logic       drop;
  int         checks = 0;
  int         fails = 0;

  always #2 clk = ~clk;

  link_drop_mon u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .rx_err_i   (rx),
    .code_err_i (code),
    .snr_err_i  (snr),
    .loss_i     (loss),
    .drop_o     (drop)
  );

  // drive mask bits: [3] rx, [2] code, [1] snr, [0] loss
  // fields: en[31:28] drive[27:24] count[23:12] expected drop index[11:0] (0 = none)
  localparam int NVEC = 13;
  localparam logic [31:0] VEC [NVEC] = '{
    {4'b1000, 4'b1000, 12'd32,  12'd32},   // R1
    {4'b1000, 4'b1000, 12'd31,  12'd0},    // R1 one short
    {4'b0100, 4'b0100, 12'd20,  12'd20},   // R2
    {4'b0100, 4'b0100, 12'd19,  12'd0},    // R2 one short
    {4'b0010, 4'b0010, 12'd20,  12'd20},   // R3
    {4'b0010, 4'b0010, 12'd19,  12'd0},    // R3 one short
    {4'b0111, 4'b1000, 12'd40,  12'd0},    // R7 rx off
    {4'b1011, 4'b0100, 12'd25,  12'd0},    // R7 code off
    {4'b1101, 4'b0010, 12'd25,  12'd0},    // R7 snr off
    {4'b0001, 4'b0001, 12'd250, 12'd250},  // R4
    {4'b0001, 4'b0001, 12'd249, 12'd0},    // R4 one short
    {4'b1110, 4'b0001, 12'd260, 12'd0},    // R7 loss off
    {4'b1111, 4'b0110, 12'd20,  12'd20}    // R5 joint hit, one pulse
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] drv, output logic d);
    rx = drv[3]; code = drv[2]; snr = drv[1]; loss = drv[0];
    @(posedge clk);
    #1 d = drop;
    @(negedge clk);
  endtask

  // returns index of first pulse (0 if none) and number of pulses
  task automatic run_seq(input logic [3:0] drv, input int n,
                         output int first_at, output int pulses);
    logic d;
    first_at = 0;
    pulses = 0;
    for (int i = 1; i <= n; i++) begin
      cyc(drv, d);
      if (d) begin
        pulses++;
        if (first_at == 0) first_at = i;
      end
    end
  endtask

  task automatic seq_chk(input logic [3:0] drv, input int n, input int exp_at,
                         input string req, input string what);
    int fa, np;
    run_seq(drv, n, fa, np);
    chk(fa == exp_at && np == ((exp_at != 0) ? 1 : 0), req, what, fa, exp_at);
  endtask

  task automatic do_reset(input logic [3:0] mask);
    rst_n = 1'b0;
    en = mask;
    rx = 1'b0; code = 1'b0; snr = 1'b0; loss = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic d;
    int   fa, np;

    // R9: reset state
    rst_n = 1'b0;
    en = 4'b1111;
    loss = 1'b1;
    rx = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk(drop === 1'b0, "R9", "drop during reset", int'(drop), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(4'b0000, d);
    chk(d === 1'b0, "R9", "drop first cycle after reset", int'(d), 0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      do_reset(VEC[v][31:28]);
      run_seq(VEC[v][27:24], int'(VEC[v][23:12]), fa, np);
      chk(fa == int'(VEC[v][11:0]) && np == ((VEC[v][11:0] != 0) ? 1 : 0),
          "R1/R2/R3/R4/R5/R7", $sformatf("vector %0d first pulse", v),
          fa, int'(VEC[v][11:0]));
      run_seq(4'b0000, 2, fa, np);
      chk(np == 0, "R5", $sformatf("vector %0d trailing pulses", v), np, 0);
    end

    // R6: counts clear at window end
    do_reset(4'b1000);
    seq_chk(4'b1000, 31, 0, "R6", "31 events early in window");
    seq_chk(4'b0000, 219, 0, "R6", "idle to window end");
    seq_chk(4'b1000, 1, 0, "R6", "first event of new window");
    seq_chk(4'b1000, 31, 31, "R6", "32nd event of new window");

    // R6: threshold reached in last window cycle
    do_reset(4'b1000);
    seq_chk(4'b0000, 218, 0, "R6", "idle before tail burst");
    seq_chk(4'b1000, 32, 32, "R6", "burst ending on last window cycle");

    // R6: burst split across window boundary
    do_reset(4'b1000);
    seq_chk(4'b0000, 219, 0, "R6", "idle before split burst");
    seq_chk(4'b1000, 32, 0, "R6", "burst split 31/1 across windows");

    // R8: window restarts at drop
    do_reset(4'b1000);
    seq_chk(4'b0000, 100, 0, "R8", "idle before first burst");
    seq_chk(4'b1000, 32, 32, "R8", "drop re-phases window");
    seq_chk(4'b0000, 228, 0, "R8", "idle after drop");
    seq_chk(4'b1000, 32, 0, "R8", "burst split by restarted window");

    // R8: one source's drop clears the others
    do_reset(4'b0110);
    seq_chk(4'b0100, 19, 0, "R8", "code events below threshold");
    seq_chk(4'b0010, 20, 20, "R3", "snr drop with code pending");
    seq_chk(4'b0100, 1, 0, "R8", "code count cleared by snr drop");
    seq_chk(4'b0100, 19, 19, "R2", "code drop from fresh count");

    // R4: glitch restarts interval, held level drops again
    do_reset(4'b0001);
    seq_chk(4'b0001, 100, 0, "R4", "loss before glitch");
    seq_chk(4'b0000, 1, 0, "R4", "glitch low");
    seq_chk(4'b0001, 249, 0, "R4", "loss one short after glitch");
    seq_chk(4'b0001, 1, 1, "R4", "loss full interval");
    seq_chk(4'b0001, 250, 250, "R5", "held loss one pulse per interval");

    // R7: disabling clears the count
    do_reset(4'b1000);
    seq_chk(4'b1000, 20, 0, "R7", "events before disable");
    en = 4'b0000;
    seq_chk(4'b1000, 1, 0, "R7", "event while disabled");
    en = 4'b1000;
    seq_chk(4'b1000, 31, 0, "R7", "31 events after re-enable");
    seq_chk(4'b1000, 1, 1, "R1", "32nd event after re-enable");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule